// File: doc/BRIEF.md
# Smart Card Character Transceiver

This block moves single bytes across one shared, open-drain smart card I/O wire in half duplex. Each character is framed as a low start bit, eight data bits and a parity bit. The block serves both directions from one sequencer. When it receives a character with bad parity, it pulls the wire low for one bit time so that the sender knows to repeat it. When it sends a character, it checks the same window for such a pulse from the card and sends the byte again without help from the host, up to a programmed number of retries.

The host offers bytes through a valid/ready pair and sees the outcome as a one-cycle done or error pulse. Received bytes come back as a one-cycle valid pulse with a parity-error flag. Three static configuration inputs set the convention: bit order, level inversion and parity sense. The bit time (etu) is set in system clock cycles by a half-etu divider input.

Top module: `sc_char_xcvr`

## Requirements
- R1: One etu is 2*`half_etu` clock cycles. A frame on the wire is a low start bit, then 8 data bits, then 1 parity bit, each lasting one etu. The start bit is never inverted.
- R2: With `cfg_msb_first`=0 and `cfg_invert`=0 (direct convention), data goes out bit 0 first at true level. `cfg_msb_first`=1 sends bit 7 first. `cfg_invert`=1 inverts each data bit on the wire.
- R3: The parity bit level is the XOR of the 8 data bits as they appear on the wire, XORed with `cfg_odd` (0 gives even parity, 1 gives odd parity).
- R4: `tx_ready` is high only while the block is idle with the wire released, and it drops in the cycle after a byte is accepted. A clean frame ends with a `tx_done` pulse 12 etu after the start bit begins, which leaves at least 2 etu of released wire after the parity bit.
- R5: If the wire reads low at 11 etu into a transmitted frame, the same byte is sent again, with its new start bit beginning 14 etu after the previous one.
- R6: Once `retry_max` retransmissions have been sent and the last one is also refused, the block raises a single `tx_err` pulse, sends no more frames and returns to idle. `tx_done` and `tx_err` are never high together.
- R7: A received frame's bits are sampled at mid-etu. One etu is counted from the synchronized falling edge of the start bit. `rx_valid` pulses for one cycle after the parity bit, with `rx_data` decoded under the same bit-order and inversion rules as R2.
- R8: A received byte whose parity fails the R3 rule is still delivered, with `rx_perr`=1. A byte that passes has `rx_perr`=0.
- R9: On a parity error, `line_drive_low` is high for exactly one etu, starting 10.5 etu after the detected start edge. On a good byte, the wire is not pulled low.
- R10: The block only pulls the wire low or releases it. After reset it releases the wire, is ready, and emits no pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_etu | input | DIV_W | Clock cycles per half bit time (at least 2) |
| cfg_msb_first | input | 1 | 1 = bit 7 first on the wire |
| cfg_invert | input | 1 | 1 = invert data bits on the wire |
| cfg_odd | input | 1 | 1 = odd parity, 0 = even parity |
| retry_max | input | RTY_W | Maximum automatic retransmissions per byte |
| tx_valid | input | 1 | Host offers a byte |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Block accepts a byte this cycle |
| tx_done | output | 1 | Pulse: byte accepted by the card |
| tx_err | output | 1 | Pulse: retries exhausted, byte dropped |
| rx_valid | output | 1 | Pulse: byte received |
| rx_data | output | 8 | Received byte |
| rx_perr | output | 1 | Received byte failed parity |
| line_in | input | 1 | Sampled level of the shared wire |
| line_drive_low | output | 1 | 1 = pull the wire low, 0 = release it |

## Verification
The bench builds the block with default widths and runs it at `half_etu`=6, so one etu is 12 cycles. At that rate, the two-flop wire synchronizer and the start-edge detection add a three-cycle offset to the receive timeline that stays well inside one etu. This lets the bench sample every bit and the error pulse edges on exact cycles. `retry_max` is set to 3, 1 and 0 in turn, which covers a successful retry, exhaustion after one retry, and failure on the first refusal. The card model shares the wire through a wired-AND, so the transmitter's error sample is tested against the real wire level.

// File: rtl/sc_xcvr_pkg.sv
package sc_xcvr_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_TX, ST_RX} xcvr_state_e;

  localparam int DATA_BITS  = 8;
  localparam int FRAME_BITS = DATA_BITS + 2;
  localparam int HCNT_W     = 5;
  localparam int BIDX_W     = HCNT_W - 1;

  // half-etu counts measured from the start-bit edge
  localparam logic [HCNT_W-1:0] H_BITS_END   = HCNT_W'(2 * FRAME_BITS);
  localparam logic [HCNT_W-1:0] H_ERR_FIRST  = HCNT_W'(2 * FRAME_BITS + 1);
  localparam logic [HCNT_W-1:0] H_ERR_LAST   = HCNT_W'(2 * FRAME_BITS + 2);
  localparam logic [HCNT_W-1:0] H_FRAME_LAST = HCNT_W'(2 * FRAME_BITS + 3);
  localparam logic [HCNT_W-1:0] H_RETRY_LAST = HCNT_W'(2 * FRAME_BITS + 7);

  // byte -> wire-order levels (index 0 goes out first)
  function automatic logic [DATA_BITS-1:0] wire_order(input logic [DATA_BITS-1:0] d,
                                                       input logic msb, input logic inv);
    logic [DATA_BITS-1:0] w;
    for (int i = 0; i < DATA_BITS; i++)
      w[i] = (msb ? d[DATA_BITS-1-i] : d[i]) ^ inv;
    return w;
  endfunction

  // wire-order levels -> byte
  function automatic logic [DATA_BITS-1:0] byte_order(input logic [DATA_BITS-1:0] w,
                                                       input logic msb, input logic inv);
    logic [DATA_BITS-1:0] d;
    for (int i = 0; i < DATA_BITS; i++) begin
      if (msb) d[DATA_BITS-1-i] = w[i] ^ inv;
      else     d[i]             = w[i] ^ inv;
    end
    return d;
  endfunction

endpackage

// File: rtl/sc_line_sync.sv
module sc_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q, q_n;

  always_comb q_n = {q[STAGES-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '1;
    else        q <= q_n;
  end

  assign dout = q[STAGES-1];
endmodule

// File: rtl/sc_etu_timer.sv
module sc_etu_timer #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_etu,
  output logic             htick
);
  logic [DIV_W-1:0] cnt, cnt_n;

  assign htick = run && (cnt == half_etu - DIV_W'(1));

  always_comb begin
    if (!run || htick) cnt_n = '0;
    else               cnt_n = cnt + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end
endmodule

// File: rtl/sc_char_xcvr.sv
module sc_char_xcvr
  import sc_xcvr_pkg::*;
#(
  parameter int DIV_W       = 12,
  parameter int RTY_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_etu,
  input  logic             cfg_msb_first,
  input  logic             cfg_invert,
  input  logic             cfg_odd,
  input  logic [RTY_W-1:0] retry_max,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  output logic             tx_ready,
  output logic             tx_done,
  output logic             tx_err,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             rx_perr,
  input  logic             line_in,
  output logic             line_drive_low
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  logic line_s, htick;
  xcvr_state_e st, st_n;

  sc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_i_n), .din(line_in), .dout(line_s));

  sc_etu_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_i_n), .run(st != ST_IDLE),
    .half_etu(half_etu), .htick(htick));

  logic [HCNT_W-1:0]     hcnt, hcnt_n;
  logic [FRAME_BITS-1:0] frame, frame_n;
  logic [DATA_BITS-1:0]  rxsh, rxsh_n;
  logic [RTY_W-1:0]      rcnt, rcnt_n;
  logic                  refused, refused_n;
  logic                  perr, perr_n;
  logic                  done_n, terr_n, rxv_n, rxp_n;
  logic [7:0]            rxd_n;
  logic [BIDX_W-1:0]     bidx;
  logic [DATA_BITS-1:0]  tx_wire;
  logic [FRAME_BITS-1:0] frame_sh;

  assign bidx     = hcnt[HCNT_W-1:1];
  assign tx_wire  = wire_order(tx_data, cfg_msb_first, cfg_invert);
  assign tx_ready = (st == ST_IDLE) && line_s;

  always_comb begin
    st_n = st;  hcnt_n = hcnt;  frame_n = frame;  rxsh_n = rxsh;
    rcnt_n = rcnt;  refused_n = refused;  perr_n = perr;
    done_n = 1'b0;  terr_n = 1'b0;  rxv_n = 1'b0;
    rxd_n = rx_data;  rxp_n = rx_perr;
    unique case (st)
      ST_IDLE: begin
        if (!line_s) begin
          st_n = ST_RX;  hcnt_n = '0;  perr_n = 1'b0;
        end else if (tx_valid) begin
          st_n = ST_TX;  hcnt_n = '0;  rcnt_n = '0;  refused_n = 1'b0;
          frame_n = {(^tx_wire) ^ cfg_odd, tx_wire, 1'b0};
        end
      end
      ST_TX: if (htick) begin
        hcnt_n = hcnt + HCNT_W'(1);
        if (hcnt == H_ERR_FIRST) refused_n = !line_s;   // wire level at 11 etu
        if (hcnt == H_FRAME_LAST && !refused) begin
          st_n = ST_IDLE;  done_n = 1'b1;
        end else if (hcnt == H_FRAME_LAST && rcnt == retry_max) begin
          st_n = ST_IDLE;  terr_n = 1'b1;
        end else if (hcnt == H_RETRY_LAST) begin
          hcnt_n = '0;  rcnt_n = rcnt + RTY_W'(1);  refused_n = 1'b0;
        end
      end
      ST_RX: if (htick) begin
        hcnt_n = hcnt + HCNT_W'(1);
        if (!hcnt[0] && hcnt < H_BITS_END) begin       // mid-bit sample
          if (bidx == '0) begin
            if (line_s) st_n = ST_IDLE;                   // start bit gone: glitch
          end else if (bidx <= BIDX_W'(DATA_BITS)) begin
            rxsh_n = {line_s, rxsh[DATA_BITS-1:1]};
          end else begin
            perr_n = (line_s != ((^rxsh) ^ cfg_odd));
            rxp_n  = perr_n;
            rxv_n  = 1'b1;
            rxd_n  = byte_order(rxsh, cfg_msb_first, cfg_invert);
          end
        end
        if (hcnt == H_FRAME_LAST) st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st <= ST_IDLE;  hcnt <= '0;  frame <= '1;  rxsh <= '0;  rcnt <= '0;
      refused <= 1'b0;  perr <= 1'b0;
      tx_done <= 1'b0;  tx_err <= 1'b0;  rx_valid <= 1'b0;
      rx_data <= '0;  rx_perr <= 1'b0;
    end else begin
      st <= st_n;  hcnt <= hcnt_n;  frame <= frame_n;  rxsh <= rxsh_n;  rcnt <= rcnt_n;
      refused <= refused_n;  perr <= perr_n;
      tx_done <= done_n;  tx_err <= terr_n;  rx_valid <= rxv_n;
      rx_data <= rxd_n;  rx_perr <= rxp_n;
    end
  end

  // open-drain drive: own frame bits while sending, error pulse while receiving
  assign frame_sh = frame >> bidx;
  always_comb begin
    line_drive_low = 1'b0;
    if (st == ST_TX && hcnt < H_BITS_END)
      line_drive_low = !frame_sh[0];
    else if (st == ST_RX && perr && (hcnt == H_ERR_FIRST || hcnt == H_ERR_LAST))
      line_drive_low = 1'b1;
  end
endmodule

// File: rtl/sc_char_xcvr_chk.sv
module sc_char_xcvr_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_valid,
  input logic tx_ready,
  input logic tx_done,
  input logic tx_err,
  input logic rx_valid,
  input logic line_drive_low
);
  // R4
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
  // R4
  done_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> !line_drive_low);
  // R6
  done_err_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_done && tx_err));
  // R7
  rx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R7
  rx_not_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !tx_ready);
  // R10
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !line_drive_low);
endmodule

bind sc_char_xcvr sc_char_xcvr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_done(tx_done), .tx_err(tx_err), .rx_valid(rx_valid),
  .line_drive_low(line_drive_low));

// File: tb/sc_char_xcvr_test.sv
module sc_char_xcvr_test;
  localparam int DIV_W = 12;
  localparam int RTY_W = 3;
  localparam int HALF  = 6;
  localparam int ETU   = 2 * HALF;
  localparam int RETRY_SPAN = 14 * ETU;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n;
  logic [DIV_W-1:0] half_etu;
  logic             cfg_msb_first, cfg_invert, cfg_odd;
  logic [RTY_W-1:0] retry_max;
  logic             tx_valid;
  logic [7:0]       tx_data;
  logic             tx_ready, tx_done, tx_err, rx_valid, rx_perr, line_drive_low;
  logic [7:0]       rx_data;
  logic             card_low;
  logic             line_w;

  assign line_w = ~(line_drive_low | card_low);

  sc_char_xcvr #(.DIV_W(DIV_W), .RTY_W(RTY_W)) uut (
    .clk(clk), .rst_n(rst_n), .half_etu(half_etu),
    .cfg_msb_first(cfg_msb_first), .cfg_invert(cfg_invert), .cfg_odd(cfg_odd),
    .retry_max(retry_max), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .tx_done(tx_done), .tx_err(tx_err),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr),
    .line_in(line_w), .line_drive_low(line_drive_low));

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected wire level of frame bit k (0 start, 1..8 data, 9 parity), per R1-R3
  function automatic bit wire_lvl(input logic [7:0] d, input int k);
    bit p;
    bit [7:0] w;
    for (int i = 0; i < 8; i++) begin
      if (cfg_msb_first) w[i] = d[7-i];
      else               w[i] = d[i];
      w[i] = w[i] ^ cfg_invert;
    end
    p = cfg_odd;
    for (int i = 0; i < 8; i++) p = p ^ w[i];
    if (k == 0) return 1'b0;
    if (k <= 8) return w[k-1];
    return p;
  endfunction

  task automatic idle_gap();
    repeat (20) @(negedge clk);
  endtask

  // sends d; the card refuses the first err_frames frames
  task automatic tx_case(input logic [7:0] d, input int err_frames, input int frames,
                         input bit exp_err, input string tag);
    int n_done = 0;
    int n_err  = 0;
    @(negedge clk);
    chk(tag, "tx_ready before send (R4)", tx_ready, 1);
    tx_valid = 1'b1;
    tx_data  = d;
    for (int j = 0; j < frames * RETRY_SPAN + ETU; j++) begin
      int f;
      int o;
      @(negedge clk);
      if (j == 0) tx_valid = 1'b0;
      f = j / RETRY_SPAN;
      o = j % RETRY_SPAN;
      if (tx_done) n_done++;
      if (tx_err)  n_err++;
      if (f < frames) begin
        if ((o % ETU) == HALF && o < 10 * ETU)
          chk(tag, $sformatf("frame %0d bit %0d level", f, o / ETU), line_w, wire_lvl(d, o / ETU));
        if (o == 5 * ETU) chk(tag, "tx_ready low in frame (R4)", tx_ready, 0);
        if (f < frames - 1 && o == 13 * ETU + HALF)
          chk(tag, "wire released before retry (R5)", line_w, 1);
        if (f == frames - 1 && o == 12 * ETU) begin
          if (exp_err) chk(tag, "tx_err at 12 etu (R6)", tx_err, 1);
          else         chk(tag, "tx_done at 12 etu (R4)", tx_done, 1);
        end
      end else if (o == HALF) begin
        chk(tag, "no further frame (R6)", line_w, 1);
        chk(tag, "tx_ready back (R4)", tx_ready, 1);
      end
      card_low = (f < err_frames) && (o >= 21 * HALF) && (o < 23 * HALF);
    end
    chk(tag, "tx_done count", n_done, exp_err ? 0 : 1);
    chk(tag, "tx_err count (R6)", n_err, exp_err ? 1 : 0);
    idle_gap();
  endtask

  // card sends d; corrupt flips its parity bit
  task automatic rx_case(input logic [7:0] d, input bit corrupt, input string tag);
    int n_v = 0;
    int v_at = -1;
    logic [7:0] got = '0;
    bit got_p = 1'b0;
    for (int j = 0; j < 172; j++) begin
      @(negedge clk);
      if (rx_valid) begin n_v++; v_at = j; got = rx_data; got_p = rx_perr; end
      if (j == 120) chk(tag, "no pull at 10 etu (R9)", line_drive_low, 0);
      if (j == 128) chk(tag, "no pull before pulse (R9)", line_drive_low, 0);
      if (j == 129) chk(tag, "pulse begins at 10.5 etu (R9)", line_drive_low, corrupt);
      if (j == 140) chk(tag, "pulse still on (R9)", line_drive_low, corrupt);
      if (j == 141) chk(tag, "pulse over after 1 etu (R9)", line_drive_low, 0);
      if (j < 10 * ETU) begin
        bit b;
        b = wire_lvl(d, j / ETU);
        if (j / ETU == 9 && corrupt) b = ~b;
        card_low = ~b;
      end else begin
        card_low = 1'b0;
      end
    end
    chk(tag, "rx_valid pulse count (R7)", n_v, 1);
    chk(tag, "rx_valid cycle (R7)", v_at, 117);
    chk(tag, "rx_data (R7)", int'(got), int'(d));
    chk(tag, "rx_perr (R8)", got_p, corrupt);
    idle_gap();
  endtask

  task automatic test_reset();
    chk("R10", "tx_ready after reset", tx_ready, 1);
    chk("R10", "line_drive_low after reset", line_drive_low, 0);
    chk("R10", "rx_valid after reset", rx_valid, 0);
    chk("R10", "tx_done after reset", tx_done, 0);
    chk("R10", "tx_err after reset", tx_err, 0);
  endtask

  task automatic test_tx_direct();
    cfg_msb_first = 0; cfg_invert = 0; cfg_odd = 0; retry_max = 3;
    tx_case(8'hA5, 0, 1, 1'b0, "R1 R2 R3 direct tx");
    tx_case(8'h01, 0, 1, 1'b0, "R2 direct tx lsb");
  endtask

  task automatic test_tx_inverse();
    cfg_msb_first = 1; cfg_invert = 1; cfg_odd = 1; retry_max = 3;
    tx_case(8'h3C, 0, 1, 1'b0, "R2 R3 msb/invert/odd tx");
    cfg_msb_first = 1; cfg_invert = 0; cfg_odd = 0;
    tx_case(8'h80, 0, 1, 1'b0, "R2 msb tx");
  endtask

  task automatic test_tx_retry_ok();
    cfg_msb_first = 0; cfg_invert = 0; cfg_odd = 0; retry_max = 3;
    tx_case(8'h96, 1, 2, 1'b0, "R5 single refusal");
  endtask

  task automatic test_tx_retry_exhaust();
    cfg_msb_first = 0; cfg_invert = 0; cfg_odd = 1; retry_max = 1;
    tx_case(8'h0F, 2, 2, 1'b1, "R6 limit one");
    retry_max = 0;
    tx_case(8'h5E, 1, 1, 1'b1, "R6 limit zero");
  endtask

  task automatic test_rx_good();
    cfg_msb_first = 0; cfg_invert = 0; cfg_odd = 0;
    rx_case(8'h5A, 1'b0, "R7 direct rx");
    cfg_msb_first = 1; cfg_invert = 1; cfg_odd = 1;
    rx_case(8'hC3, 1'b0, "R7 msb/invert/odd rx");
  endtask

  task automatic test_rx_parity_err();
    cfg_msb_first = 0; cfg_invert = 0; cfg_odd = 0;
    rx_case(8'h77, 1'b1, "R8 R9 parity error rx");
    cfg_msb_first = 1; cfg_invert = 1; cfg_odd = 1;
    rx_case(8'h12, 1'b1, "R8 R9 parity error inverse rx");
  endtask

  initial begin
    rst_n = 1'b0; half_etu = DIV_W'(HALF);
    cfg_msb_first = 1'b0; cfg_invert = 1'b0; cfg_odd = 1'b0;
    retry_max = RTY_W'(3); tx_valid = 1'b0; tx_data = '0; card_low = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    test_reset();
    test_tx_direct();
    test_tx_inverse();
    test_tx_retry_ok();
    test_tx_retry_exhaust();
    test_rx_good();
    test_rx_parity_err();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule